// File: doc/BRIEF.md
# Character Display Host Register Interface

This block sits between a host processor and the internal memories of a character display controller. The host reaches it through a parallel port of 8 or 4 data lines, a register-select line, a read/write line and a one-cycle transfer strobe. Register-select low addresses the instruction side: writes carry instructions and reads return a status byte. Register-select high addresses the data side: writes and reads move one byte to or from the memory that the most recent address-set instruction chose.

An address counter follows every data transfer and wraps at the end of the selected memory. Memory accesses leave the block as registered single-cycle requests. After reset, and again on each clear instruction, the block fills the whole display memory with the space code. It reports busy while the fill runs and for a fixed time after every accepted transfer.

Top module: `lcd_host_regif`

## Requirements
- R1: After reset the status busy bit (bit 7) reads 1 while every display address 0..DISP_DEPTH-1 receives the value 20h. Busy then clears with the address counter at 0.
- R2: A read with host_rs=0 returns the busy flag on bit 7 and the address counter on bits 6..0. It is served even while busy.
- R3: While busy, instruction writes, data writes and data reads are ignored: no memory request is issued and the address counter does not change.
- R4: Each accepted instruction (other than clear) and each accepted data transfer keeps busy set for CMD_BUSY cycles. Instruction 01h sets the counter to 0, selects display memory and rewrites all display addresses with 20h while busy. Character-generator contents survive the clear.
- R5: Address-set codes: 1aaaaaaa selects display memory (a value of DISP_DEPTH or more loads 0); 011aaaaa selects character-generator memory; 0100aaaa selects segment memory; 0101aaaa selects annunciator memory. ram_space carries 0 display, 1 character generator, 2 segment, 3 annunciator.
- R6: A data write raises ram_we for one cycle at the counter address. It sends the full byte to display or annunciator memory, and only bits 4..0 (bits 7..5 zero) to character-generator or segment memory.
- R7: After each accepted data read or write the counter adds one, and it wraps to 0 after the last address (DISP_DEPTH-1, CG_DEPTH-1, SEG_DEPTH-1 or ANN_DEPTH-1).
- R8: A data read raises ram_re for one cycle at the counter address. ram_rdata must be valid in that cycle, and the byte appears on host_rdata from the second clock edge after the strobe. ram_we and ram_re are never high together.
- R9: With host_wide=0 each byte moves as two transfers on data lines 7..4, upper nibble first. Reads present the upper nibble and then the lower nibble on host_rdata[7:4], with host_rdata[3:0] at 0.
- R10: The nibble phase returns to "upper" after reset and whenever host_wide changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wide | input | 1 | 1 = 8-bit transfers, 0 = 4-bit transfers |
| host_rs | input | 1 | 0 = instruction/status, 1 = data |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_stb | input | 1 | One-cycle transfer strobe |
| host_wdata | input | 8 | Write data (nibbles on bits 7..4) |
| host_rdata | output | 8 | Read data (nibbles on bits 7..4) |
| ram_we | output | 1 | Memory write request |
| ram_re | output | 1 | Memory read request |
| ram_space | output | 2 | Target memory code |
| ram_addr | output | 7 | Memory address |
| ram_wdata | output | 8 | Memory write data |
| ram_rdata | input | 8 | Memory read data, valid while ram_re is high |

## Verification
The hardest state to reach from the ports is a 4-bit host that has fallen out of step. A stray single nibble leaves the phase pointing at "lower", and only a width change can realign it. The stimulus sends one lone nibble, flips host_wide away and back, and then requires a full address-set pair to land on the intended address. The ignored-while-busy rule is reached in a similar way. A data write is sent two cycles after an instruction, inside the busy window, and the bench then reads the counter and the memory contents back to confirm the write left no trace.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;
  localparam int AC_W = 7;
  localparam logic [7:0] SPACE_CODE = 8'h20;
  localparam logic [7:0] OP_CLEAR   = 8'h01;

  typedef enum logic [1:0] {
    SP_DISP = 2'd0,
    SP_CGEN = 2'd1,
    SP_SEG  = 2'd2,
    SP_ANN  = 2'd3
  } space_t;
endpackage

// File: rtl/lcd_nibble_join.sv
module lcd_nibble_join (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wide,
  input  logic       stb,
  input  logic [7:0] din,
  output logic       first,
  output logic       done,
  output logic       nib_hi,
  output logic [7:0] byte_o
);
  logic       wide_q, phase_q, phase_n;
  logic [3:0] hold_q, hold_n;
  logic       up;

  // a width change forces the upper phase in the same cycle
  assign up     = (wide != wide_q) | phase_q;
  assign first  = stb & (wide | up);
  assign done   = stb & (wide | ~up);
  assign byte_o = wide ? din : {hold_q, din[7:4]};
  assign nib_hi = phase_q;

  always_comb begin
    hold_n  = hold_q;
    phase_n = up;
    if (wide) begin
      phase_n = 1'b1;
    end else if (stb) begin
      phase_n = ~up;
      if (up) hold_n = din[7:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q  <= 1'b1;
      phase_q <= 1'b1;
      hold_q  <= 4'h0;
    end else begin
      wide_q  <= wide;
      phase_q <= phase_n;
      hold_q  <= hold_n;
    end
  end
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)              cnt_n = CW'(CYC);
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/lcd_addr_ctr.sv
module lcd_addr_ctr
  import lcd_regif_pkg::*;
#(
  parameter int DISP_DEPTH = 60,
  parameter int CG_DEPTH   = 32,
  parameter int SEG_DEPTH  = 16,
  parameter int ANN_DEPTH  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            zero,
  input  logic            set,
  input  space_t          set_sp,
  input  logic [AC_W-1:0] set_val,
  input  logic            inc,
  output logic [AC_W-1:0] ac,
  output space_t          space
);
  logic [AC_W-1:0] ac_q, ac_n, last_cur, last_set;
  space_t          sp_q, sp_n;

  function automatic logic [AC_W-1:0] last_of(input space_t s);
    case (s)
      SP_DISP: last_of = AC_W'(DISP_DEPTH - 1);
      SP_CGEN: last_of = AC_W'(CG_DEPTH - 1);
      SP_SEG:  last_of = AC_W'(SEG_DEPTH - 1);
      default: last_of = AC_W'(ANN_DEPTH - 1);
    endcase
  endfunction

  assign last_cur = last_of(sp_q);
  assign last_set = last_of(set_sp);

  always_comb begin
    ac_n = ac_q;
    sp_n = sp_q;
    if (zero) begin
      ac_n = '0;
      sp_n = SP_DISP;
    end else if (set) begin
      sp_n = set_sp;
      ac_n = (set_val > last_set) ? '0 : set_val;
    end else if (inc) begin
      ac_n = (ac_q == last_cur) ? '0 : ac_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      sp_q <= SP_DISP;
    end else begin
      ac_q <= ac_n;
      sp_q <= sp_n;
    end
  end

  assign ac    = ac_q;
  assign space = sp_q;
endmodule

// File: rtl/lcd_host_regif.sv
module lcd_host_regif
  import lcd_regif_pkg::*;
#(
  parameter int DISP_DEPTH = 60,
  parameter int CG_DEPTH   = 32,
  parameter int SEG_DEPTH  = 16,
  parameter int ANN_DEPTH  = 16,
  parameter int CMD_BUSY   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wide,
  input  logic                host_rs,
  input  logic                host_rd,
  input  logic                host_stb,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  output logic                ram_we,
  output logic                ram_re,
  output logic [1:0]          ram_space,
  output logic [AC_W-1:0]     ram_addr,
  output logic [7:0]          ram_wdata,
  input  logic [7:0]          ram_rdata
);
  localparam logic [AC_W-1:0] FILL_LAST = AC_W'(DISP_DEPTH - 1);

  logic            first, done, nib_hi;
  logic [7:0]      byte_w;
  logic            tmr_busy, busy;
  logic            instr_ok, dwr_ok, drd_ok, srd, is_clear;
  logic            set_en;
  space_t          set_sp, space;
  logic [AC_W-1:0] set_val, ac;
  logic            fill_on, fill_on_n;
  logic [AC_W-1:0] fill_idx, fill_idx_n;
  logic            we_q, we_n, re_q, re_n;
  space_t          sp_q, sp_n;
  logic [AC_W-1:0] addr_q, addr_n;
  logic [7:0]      wd_q, wd_n, rd_q, rd_n;

  lcd_nibble_join u_join (
    .clk(clk), .rst_n(rst_n), .wide(host_wide), .stb(host_stb),
    .din(host_wdata), .first(first), .done(done), .nib_hi(nib_hi),
    .byte_o(byte_w)
  );

  assign busy     = fill_on | tmr_busy;
  assign instr_ok = done  & ~host_rd & ~host_rs & ~busy;
  assign dwr_ok   = done  & ~host_rd &  host_rs & ~busy;
  assign drd_ok   = first &  host_rd &  host_rs & ~busy;
  assign srd      = first &  host_rd & ~host_rs;
  assign is_clear = instr_ok & (byte_w == OP_CLEAR);

  always_comb begin
    set_en  = 1'b0;
    set_sp  = SP_DISP;
    set_val = '0;
    if (instr_ok) begin
      if (byte_w[7]) begin
        set_en = 1'b1; set_sp = SP_DISP; set_val = byte_w[6:0];
      end else if (byte_w[6:5] == 2'b11) begin
        set_en = 1'b1; set_sp = SP_CGEN; set_val = AC_W'(byte_w[4:0]);
      end else if (byte_w[6:4] == 3'b100) begin
        set_en = 1'b1; set_sp = SP_SEG;  set_val = AC_W'(byte_w[3:0]);
      end else if (byte_w[6:4] == 3'b101) begin
        set_en = 1'b1; set_sp = SP_ANN;  set_val = AC_W'(byte_w[3:0]);
      end
    end
  end

  lcd_busy_timer #(.CYC(CMD_BUSY)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load((instr_ok & ~is_clear) | dwr_ok | drd_ok),
    .busy(tmr_busy)
  );

  lcd_addr_ctr #(
    .DISP_DEPTH(DISP_DEPTH), .CG_DEPTH(CG_DEPTH),
    .SEG_DEPTH(SEG_DEPTH), .ANN_DEPTH(ANN_DEPTH)
  ) u_ac (
    .clk(clk), .rst_n(rst_n), .zero(is_clear), .set(set_en),
    .set_sp(set_sp), .set_val(set_val), .inc(dwr_ok | drd_ok),
    .ac(ac), .space(space)
  );

  // fill sequencer: one display address per cycle
  always_comb begin
    fill_on_n  = fill_on;
    fill_idx_n = fill_idx;
    if (is_clear) begin
      fill_on_n  = 1'b1;
      fill_idx_n = '0;
    end else if (fill_on) begin
      if (fill_idx == FILL_LAST) fill_on_n = 1'b0;
      else                       fill_idx_n = fill_idx + 1'b1;
    end
  end

  // memory request and read-back registers
  always_comb begin
    we_n   = fill_on | dwr_ok;
    re_n   = drd_ok;
    sp_n   = fill_on ? SP_DISP : space;
    addr_n = fill_on ? fill_idx : ac;
    wd_n   = wd_q;
    if (fill_on)     wd_n = SPACE_CODE;
    else if (dwr_ok) wd_n = (space == SP_CGEN || space == SP_SEG) ?
                            {3'b000, byte_w[4:0]} : byte_w;
    rd_n = rd_q;
    if (srd)       rd_n = {busy, ac};
    else if (re_q) rd_n = ram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_on  <= 1'b1;
      fill_idx <= '0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      sp_q     <= SP_DISP;
      addr_q   <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
    end else begin
      fill_on  <= fill_on_n;
      fill_idx <= fill_idx_n;
      we_q     <= we_n;
      re_q     <= re_n;
      sp_q     <= sp_n;
      addr_q   <= addr_n;
      wd_q     <= wd_n;
      rd_q     <= rd_n;
    end
  end

  assign ram_we     = we_q;
  assign ram_re     = re_q;
  assign ram_space  = sp_q;
  assign ram_addr   = addr_q;
  assign ram_wdata  = wd_q;
  assign host_rdata = host_wide ? rd_q :
                      {(nib_hi ? rd_q[3:0] : rd_q[7:4]), 4'h0};
endmodule

// File: rtl/lcd_host_regif_chk.sv
module lcd_host_regif_chk #(
  parameter int DISP_DEPTH = 60,
  parameter int CG_DEPTH   = 32,
  parameter int SEG_DEPTH  = 16,
  parameter int ANN_DEPTH  = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ram_we,
  input logic       ram_re,
  input logic [1:0] ram_space,
  input logic [7:0] ram_wdata,
  input logic       fill_on,
  input logic       busy,
  input logic [6:0] ac,
  input logic [1:0] space
);
  int lim;
  always_comb begin
    case (space)
      2'd0:    lim = DISP_DEPTH;
      2'd1:    lim = CG_DEPTH;
      2'd2:    lim = SEG_DEPTH;
      default: lim = ANN_DEPTH;
    endcase
  end

  AST_FILL_WRITES_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_on |=> (ram_we && ram_wdata == 8'h20 && ram_space == 2'd0)); // R1

  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !$past(fill_on)) |-> !$past(busy)); // R3

  AST_NARROW_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && (ram_space == 2'd1 || ram_space == 2'd2)) |-> ram_wdata[7:5] == 3'b000); // R6

  AST_AC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ac) < lim); // R7

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re)); // R8
endmodule

bind lcd_host_regif lcd_host_regif_chk #(
  .DISP_DEPTH(DISP_DEPTH), .CG_DEPTH(CG_DEPTH),
  .SEG_DEPTH(SEG_DEPTH), .ANN_DEPTH(ANN_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_re(ram_re),
  .ram_space(ram_space), .ram_wdata(ram_wdata), .fill_on(fill_on),
  .busy(busy), .ac(ac), .space(space)
);

// File: tb/tb_lcd_host_regif.sv
module tb_lcd_host_regif;
  localparam int DEPTH = 60;
  localparam int NBUSY = 4;
  localparam int NVEC  = 31;
  localparam logic [1:0] K_I = 2'd0, K_W = 2'd1, K_R = 2'd2, K_S = 2'd3;

  // {kind, data, expected}
  localparam logic [17:0] VEC [NVEC] = '{
    {K_I, 8'h85, 8'h00}, {K_W, 8'h41, 8'h00}, {K_W, 8'h42, 8'h00},   // R5 R6
    {K_I, 8'h85, 8'h00}, {K_R, 8'h00, 8'h41}, {K_R, 8'h00, 8'h42},   // R8
    {K_S, 8'h00, 8'h07},                                             // R2 R7
    {K_I, 8'h7F, 8'h00}, {K_W, 8'hFF, 8'h00}, {K_S, 8'h00, 8'h00},   // R7 wrap 31
    {K_I, 8'h7F, 8'h00}, {K_R, 8'h00, 8'h1F},                        // R6 low bits
    {K_I, 8'hBB, 8'h00}, {K_W, 8'h33, 8'h00}, {K_S, 8'h00, 8'h00},   // R7 wrap 59
    {K_I, 8'h8A, 8'h00}, {K_S, 8'h00, 8'h0A},                        // R5
    {K_I, 8'hC0, 8'h00}, {K_S, 8'h00, 8'h00},                        // R5 out of range
    {K_I, 8'h5E, 8'h00}, {K_W, 8'hA5, 8'h00}, {K_W, 8'h5A, 8'h00},
    {K_S, 8'h00, 8'h00},                                             // R7 wrap 15
    {K_I, 8'h5E, 8'h00}, {K_R, 8'h00, 8'hA5},                        // R6 full byte
    {K_I, 8'h43, 8'h00}, {K_W, 8'hEE, 8'h00},
    {K_I, 8'h43, 8'h00}, {K_R, 8'h00, 8'h0E},                        // R6 segment
    {K_I, 8'hBB, 8'h00}, {K_R, 8'h00, 8'h33}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wide = 1'b1, host_rs = 1'b0, host_rd = 1'b0, host_stb = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, ram_wdata, ram_rdata;
  logic       ram_we, ram_re;
  logic [1:0] ram_space;
  logic [6:0] ram_addr;
  logic [7:0] mem [512];
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  lcd_host_regif #(.CMD_BUSY(NBUSY)) dut (
    .clk(clk), .rst_n(rst_n), .host_wide(host_wide), .host_rs(host_rs),
    .host_rd(host_rd), .host_stb(host_stb), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_space(ram_space), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  assign ram_rdata = mem[{ram_space, ram_addr}];
  always @(posedge clk) if (ram_we) mem[{ram_space, ram_addr}] <= ram_wdata;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic put(input logic rs, input logic rd, input logic [7:0] d);
    @(negedge clk);
    host_rs = rs; host_rd = rd; host_wdata = d; host_stb = 1'b1;
    @(negedge clk);
    host_stb = 1'b0;
  endtask

  task automatic wr(input logic rs, input logic [7:0] d);
    if (host_wide) put(rs, 1'b0, d);
    else begin
      put(rs, 1'b0, {d[7:4], 4'h0});
      put(rs, 1'b0, {d[3:0], 4'h0});
    end
  endtask

  task automatic rdb(input logic rs, output logic [7:0] v);
    put(rs, 1'b1, 8'h00);
    @(negedge clk);
    if (host_wide) v = host_rdata;
    else begin
      v[7:4] = host_rdata[7:4];
      put(rs, 1'b1, 8'h00);
      v[3:0] = host_rdata[7:4];
    end
  endtask

  task automatic wait_ready();
    logic [7:0] v;
    for (int i = 0; i < 300; i++) begin
      rdb(1'b0, v);
      if (!v[7]) break;
    end
  endtask

  task automatic disp_all_space(input string tag);
    int miss = 0;
    for (int a = 0; a < DEPTH; a++) if (mem[a] !== 8'h20) miss++;
    check(tag, 8'(miss), 8'h00);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1..none actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    for (int a = 0; a < 512; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: busy during the power-on fill, counter 0 and spaces afterwards
    rdb(1'b0, v);
    check("R1 busy after reset", {v[7], 7'h0}, 8'h80);
    wait_ready();
    rdb(1'b0, v);
    check("R1 status after fill", v, 8'h00);
    disp_all_space("R1 display filled");

    // vector table in 8-bit mode
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] k;
      k = VEC[i][17:16];
      wait_ready();
      case (k)
        K_I: wr(1'b0, VEC[i][15:8]);
        K_W: wr(1'b1, VEC[i][15:8]);
        K_R: begin rdb(1'b1, v); check($sformatf("R6 R8 vector %0d", i), v, VEC[i][7:0]); end
        default: begin rdb(1'b0, v); check($sformatf("R2 R5 R7 vector %0d", i), v, VEC[i][7:0]); end
      endcase
    end

    // R4: busy window length after an instruction
    wait_ready();
    wr(1'b0, 8'h85);
    rdb(1'b0, v);
    check("R4 busy right after instruction", {v[7], 7'h0}, 8'h80);
    wait_ready();
    wr(1'b0, 8'h86);
    repeat (NBUSY - 2) @(negedge clk);
    rdb(1'b0, v);
    check("R4 busy at last cycle", {v[7], 7'h0}, 8'h80);
    wait_ready();
    wr(1'b0, 8'h87);
    repeat (NBUSY - 1) @(negedge clk);
    rdb(1'b0, v);
    check("R4 idle after window", v, 8'h07);

    // R3: a data write inside the busy window is dropped
    wait_ready();
    wr(1'b0, 8'h85);
    wr(1'b1, 8'h77);
    wait_ready();
    rdb(1'b0, v);
    check("R3 counter unchanged", v, 8'h05);
    check("R3 memory unchanged", mem[5], 8'h41);
    // R3: a data read inside the busy window issues no request
    wr(1'b0, 8'h85);
    put(1'b1, 1'b1, 8'h00);
    wait_ready();
    rdb(1'b0, v);
    check("R3 read ignored", v, 8'h05);

    // R4: clear instruction
    wr(1'b0, 8'h01);
    rdb(1'b0, v);
    check("R4 busy during clear", {v[7], 7'h0}, 8'h80);
    wait_ready();
    rdb(1'b0, v);
    check("R4 counter zero after clear", v, 8'h00);
    disp_all_space("R4 display cleared");
    wr(1'b0, 8'h7F);
    wait_ready();
    rdb(1'b1, v);
    check("R4 char generator kept", v, 8'h1F);

    // R9: 4-bit transfers
    wait_ready();
    host_wide = 1'b0;
    wr(1'b0, 8'h90);
    wait_ready();
    wr(1'b1, 8'h6B);
    wait_ready();
    wr(1'b0, 8'h90);
    wait_ready();
    put(1'b1, 1'b1, 8'h00);
    @(negedge clk);
    check("R9 upper nibble first", host_rdata, 8'h60);
    put(1'b1, 1'b1, 8'h00);
    check("R9 lower nibble second", host_rdata, 8'hB0);
    wait_ready();
    rdb(1'b0, v);
    check("R9 status in nibbles", v, 8'h11);

    // R10: a stray nibble realigned by a width change
    put(1'b0, 1'b0, 8'hA0);
    @(negedge clk); host_wide = 1'b1;
    @(negedge clk); host_wide = 1'b0;
    @(negedge clk);
    wr(1'b0, 8'h95);
    wait_ready();
    rdb(1'b0, v);
    check("R10 phase realigned", v, 8'h15);

    finish_run();
  end
endmodule